// File: doc/BRIEF.md
# Register-Access Packet Transmitter

This block forms request packets for a point-to-point register access link carried over a byte-serial stream. A host presents a read or write request with a page number, a starting offset, a register count and up to 32 sixteen-bit register values. The block latches the request, works out an 8-bit checksum over the packet, and then hands the packet out one byte at a time on a valid/ready byte port that feeds a UART transmitter.

Every packet starts with a four-byte header. The first header byte holds both the operation code and the register count. The checksum byte sits in the second position, so the block runs its checksum pass over the latched packet before it sends the first byte. A write appends the counted registers after the header. A read sends only the header. When the final byte has been taken, the block pulses a completion strobe. For a read, it also pulses a strobe that tells a reply receiver to start listening.

Top module: `regpkt_tx`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `tx_valid`, `done`, `expect_reply` and `req_reject` are low and `req_ready` is high.
- R2: The header goes out in this order: code/count byte, checksum byte, page byte, offset byte. The code/count byte carries the register count in bits 5:0 and the operation in bits 7:6, with read = 2'b00 (0x00) and write = 2'b01 (0x40).
- R3: A write sends the counted registers after the header. Registers go out in index order, each one low byte first then high byte, so the write packet is 4 + 2 x count bytes long.
- R4: The checksum byte is a CRC-8 with polynomial 0x07, initial value 0x00, MSB-first and no final inversion. It covers every byte of the packet as sent, in wire order, with the checksum position counted as 0x00.
- R5: A read sends only its four header bytes, and the checksum covers those four bytes alone. `expect_reply` pulses in the same cycle as `done` for a read and never for a write.
- R6: A request whose count is above 32 is refused. `req_reject` is high for one cycle in the cycle after the offer, no byte is sent, and `busy` stays low.
- R7: A request is taken only while `req_ready` is high, which is whenever the block is not busy. A request offered while busy is ignored and does not change the packet in flight.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value. The block moves to the next byte only on a handshake.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the final byte. `busy` falls in that same cycle.
- R10: A write with a count of zero sends exactly the four header bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Starting offset within the page |
| req_count | input | 6 | Number of registers |
| req_data | input | 512 | Register values; register i in bits 16i+15:16i |
| req_ready | output | 1 | Block idle and able to take a request |
| req_reject | output | 1 | One-cycle pulse: request refused for count above 32 |
| busy | output | 1 | A packet is being prepared or sent |
| tx_data | output | 8 | Byte to the UART transmitter |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_ready | input | 1 | UART transmitter takes the byte |
| done | output | 1 | One-cycle pulse when the packet is fully sent |
| expect_reply | output | 1 | One-cycle pulse with `done` after a read |

## Verification
The bench targets the count boundaries: zero, one, the full 32, and 33 and 63 on the refusal side. A wrong length rule would show up here as a packet that is truncated or too long, or as a refused request that still puts bytes on the line. Every packet is checked against a checksum that the bench computes with the checksum slot zeroed. A design that folded in the real checksum, skipped a byte or swapped register byte order would produce a mismatching second byte or misordered payload. Backpressure is applied in irregular patterns to catch a byte that advances without a handshake. A second request is held active during a send to catch a design that re-latches its fields while busy. The read path also checks that the reply strobe coincides with completion, which a design that mixed up read and write lengths or strobes would break.

// File: rtl/regpkt_pkg.sv
// Package: shared constants and types for the register-access packet transmitter.
// Assumes the packet format: 4-byte header, 16-bit registers, 6-bit count field.
package regpkt_pkg;

    localparam int HDR_BYTES = 4;
    localparam int CNT_W     = 6;
    localparam logic [7:0]  CRC_POLY = 8'h07;
    localparam logic [15:0] PAD_WORD = 16'h55AA;

    // Operation code carried in bits 7:6 of the first header byte.
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01
    } op_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CALC = 2'b01,
        ST_SEND = 2'b10
    } seq_e;

endpackage

// File: rtl/regpkt_crc8_step.sv
// Module: one byte of CRC-8 update, MSB first, as a chain of eight shift stages.
// Assumes no reflection and no final XOR; the polynomial is a parameter.
module regpkt_crc8_step #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);

    logic [7:0] stage [0:8];

    // Seed the chain with the incoming byte folded into the running value.
    assign stage[0] = crc_in ^ data_in;

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_bit
            // One shift of the division register per bit.
            assign stage[g+1] = stage[g][7] ? ({stage[g][6:0], 1'b0} ^ POLY)
                                            : {stage[g][6:0], 1'b0};
        end
    endgenerate

    assign crc_out = stage[8];

endmodule

// File: rtl/regpkt_frame_buf.sv
// Module: holds the latched request and presents the packet byte at a given index.
// Assumes the index is below the packet length; the checksum slot reads as zero here
// and is substituted by the sequencer on the wire. Unused slots hold the pad word.
module regpkt_frame_buf
    import regpkt_pkg::*;
#(
    parameter int MAX_REGS = 32,
    localparam int IDX_W   = $clog2(HDR_BYTES + 2 * MAX_REGS),
    localparam int REG_W   = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  op_e                      op_in,
    input  logic [CNT_W-1:0]         count_in,
    input  logic [7:0]               page_in,
    input  logic [7:0]               offset_in,
    input  logic [MAX_REGS*16-1:0]   data_in,
    input  logic [IDX_W-1:0]         idx,
    output logic [7:0]               byte_out
);

    op_e              op_q;
    logic [CNT_W-1:0] count_q;
    logic [7:0]       page_q;
    logic [7:0]       offset_q;
    logic [15:0]      regs_q [MAX_REGS];

    // Latch the header fields when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_READ;
            count_q  <= '0;
            page_q   <= '0;
            offset_q <= '0;
        end else if (load) begin
            op_q     <= op_in;
            count_q  <= count_in;
            page_q   <= page_in;
            offset_q <= offset_in;
        end
    end

    genvar r;
    generate
        for (r = 0; r < MAX_REGS; r++) begin : g_reg
            // Latch a counted value, or the pad word for slots past the count.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[r] <= PAD_WORD;
                end else if (load) begin
                    regs_q[r] <= (r < int'(count_in)) ? data_in[r*16 +: 16] : PAD_WORD;
                end
            end
        end
    endgenerate

    logic [IDX_W-1:0] pay_off;
    logic [REG_W-1:0] reg_sel;
    logic [15:0]      word;

    assign pay_off = idx - IDX_W'(HDR_BYTES);
    assign reg_sel = pay_off[REG_W:1];
    assign word    = regs_q[reg_sel];

    // Select the byte at the requested packet position.
    always_comb begin
        case (idx)
            IDX_W'(0): byte_out = {op_q, count_q};
            IDX_W'(1): byte_out = 8'h00;
            IDX_W'(2): byte_out = page_q;
            IDX_W'(3): byte_out = offset_q;
            default:   byte_out = pay_off[0] ? word[15:8] : word[7:0];
        endcase
    end

endmodule

// File: rtl/regpkt_seq.sv
// Module: request acceptance, checksum pass and byte streaming.
// Assumes the frame buffer answers the byte at idx in the same cycle.
// Sequence: IDLE -> CALC (one packet byte per cycle) -> SEND (one byte per handshake).
module regpkt_seq
    import regpkt_pkg::*;
#(
    parameter int MAX_REGS = 32,
    localparam int IDX_W   = $clog2(HDR_BYTES + 2 * MAX_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] req_count,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    input  logic [7:0]       buf_byte,
    output logic             req_ready,
    output logic             req_reject,
    output logic             busy,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             done,
    output logic             expect_reply
);

    seq_e             state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] len_q;
    logic [7:0]       crc_q;
    logic [7:0]       crc_next;
    logic             is_read_q;
    logic             done_q;
    logic             reply_q;
    logic             reject_q;
    logic             take;
    logic             too_many;
    logic             last;
    logic [IDX_W-1:0] len_new;

    regpkt_crc8_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_q),
        .data_in (buf_byte),
        .crc_out (crc_next)
    );

    assign too_many = int'(req_count) > MAX_REGS;
    assign take     = (state_q == ST_IDLE) && req_valid;
    assign load     = take && !too_many;
    assign last     = (idx_q == len_q - IDX_W'(1));
    assign len_new  = req_write ? IDX_W'(HDR_BYTES + 2 * int'(req_count))
                                : IDX_W'(HDR_BYTES);

    // Phase control, byte index and checksum accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            len_q     <= IDX_W'(HDR_BYTES);
            crc_q     <= '0;
            is_read_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        state_q   <= ST_CALC;
                        idx_q     <= '0;
                        len_q     <= len_new;
                        crc_q     <= '0;
                        is_read_q <= !req_write;
                    end
                end
                ST_CALC: begin
                    crc_q <= crc_next;
                    if (last) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (last) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion, reply and refusal strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            reply_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            done_q   <= (state_q == ST_SEND) && tx_ready && last;
            reply_q  <= (state_q == ST_SEND) && tx_ready && last && is_read_q;
            reject_q <= take && too_many;
        end
    end

    assign idx          = idx_q;
    assign req_ready    = (state_q == ST_IDLE);
    assign busy         = (state_q != ST_IDLE);
    assign tx_valid     = (state_q == ST_SEND);
    assign tx_data      = (idx_q == IDX_W'(1)) ? crc_q : buf_byte;
    assign done         = done_q;
    assign expect_reply = reply_q;
    assign req_reject   = reject_q;

endmodule

// File: rtl/regpkt_tx.sv
// Module: top of the register-access packet transmitter.
// Assumes a UART transmitter downstream that takes bytes on a valid/ready handshake.
module regpkt_tx
    import regpkt_pkg::*;
#(
    parameter int MAX_REGS = 32,
    localparam int IDX_W   = $clog2(HDR_BYTES + 2 * MAX_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_page,
    input  logic [7:0]             req_offset,
    input  logic [CNT_W-1:0]       req_count,
    input  logic [MAX_REGS*16-1:0] req_data,
    output logic                   req_ready,
    output logic                   req_reject,
    output logic                   busy,
    output logic [7:0]             tx_data,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic                   done,
    output logic                   expect_reply
);

    logic             load;
    logic [IDX_W-1:0] idx;
    logic [7:0]       buf_byte;
    op_e              op_sel;

    assign op_sel = req_write ? OP_WRITE : OP_READ;

    regpkt_frame_buf #(.MAX_REGS(MAX_REGS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .op_in     (op_sel),
        .count_in  (req_count),
        .page_in   (req_page),
        .offset_in (req_offset),
        .data_in   (req_data),
        .idx       (idx),
        .byte_out  (buf_byte)
    );

    regpkt_seq #(.MAX_REGS(MAX_REGS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_count    (req_count),
        .load         (load),
        .idx          (idx),
        .buf_byte     (buf_byte),
        .req_ready    (req_ready),
        .req_reject   (req_reject),
        .busy         (busy),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .done         (done),
        .expect_reply (expect_reply)
    );

endmodule

// File: rtl/regpkt_tx_chk.sv
// Module: protocol checker for the packet transmitter, bound to the top module.
// Assumes only the top-level ports are visible.
module regpkt_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_reject,
    input logic       busy,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       done,
    input logic       expect_reply
);

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !tx_valid); // R9

    AST_REPLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        expect_reply |-> done); // R5

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !busy && !tx_valid); // R6

    AST_START_ON_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready)); // R7

endmodule

bind regpkt_tx regpkt_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_reject   (req_reject),
    .busy         (busy),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .done         (done),
    .expect_reply (expect_reply)
);

// File: tb/regpkt_tx_test.sv
module regpkt_tx_test;

    localparam int NREG = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [7:0]      req_page = '0;
    logic [7:0]      req_offset = '0;
    logic [5:0]      req_count = '0;
    logic [NREG*16-1:0] req_data = '0;
    logic            tx_ready = 1'b0;
    logic            req_ready, req_reject, busy, tx_valid, done, expect_reply;
    logic [7:0]      tx_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] vals [NREG];
    logic [7:0]  expb [0:67];

    regpkt_tx #(.MAX_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_page(req_page), .req_offset(req_offset), .req_count(req_count),
        .req_data(req_data), .req_ready(req_ready), .req_reject(req_reject),
        .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .done(done), .expect_reply(expect_reply)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x = c ^ b;
        for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    function automatic bit ready_pat(input int mode, input int n);
        case (mode)
            0: return 1'b1;
            1: return (n % 3) != 0;
            default: return (n >= 5) && (n % 2 == 1);
        endcase
    endfunction

    // Build expected bytes, issue the request, collect and check the packet.
    task automatic run_frame(input bit wr, input logic [7:0] pg, input logic [7:0] of,
                             input int cnt, input int seed, input int mode, input bit spam);
        int len = wr ? 4 + 2 * cnt : 4;
        int got = 0;
        int n = 0;
        bit hold = 0;
        logic [7:0] held = '0;
        logic [7:0] c = '0;
        for (int i = 0; i < NREG; i++) vals[i] = 16'(seed * 16'h1357 + i * 16'h0A11 + 16'h0101);
        expb[0] = {wr ? 2'b01 : 2'b00, 6'(cnt)};
        expb[1] = 8'h00;
        expb[2] = pg;
        expb[3] = of;
        if (wr) for (int i = 0; i < cnt; i++) begin
            expb[4 + 2*i] = vals[i][7:0];
            expb[5 + 2*i] = vals[i][15:8];
        end
        for (int i = 0; i < len; i++) c = crc_byte(c, expb[i]);
        expb[1] = c;
        @(negedge clk);
        chk(req_ready && !busy, "R7 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_page = pg; req_offset = of;
        req_count = 6'(cnt);
        for (int i = 0; i < NREG; i++) req_data[i*16 +: 16] = vals[i];
        tx_ready = 1'b0;
        @(negedge clk);
        while (got < len && n < 2000) begin
            if (spam && got < 3) begin
                req_valid = 1'b1; req_write = !wr; req_page = ~pg; req_offset = ~of;
                req_count = 6'd7; req_data = ~req_data;
                chk(!req_ready, "R7 not ready while busy", req_ready, 0);
            end else begin
                req_valid = 1'b0;
            end
            tx_ready = ready_pat(mode, n);
            if (hold) chk(tx_valid && tx_data == held, "R8 byte held", tx_data, held);
            hold = 0;
            if (tx_valid && tx_ready) begin
                chk(tx_data == expb[got], got == 1 ? "R4 checksum byte" :
                    (got < 4 ? "R2 header byte" : "R3 payload byte"), tx_data, expb[got]);
                got++;
            end else if (tx_valid) begin
                hold = 1; held = tx_data;
            end
            n++;
            if (got < len) @(negedge clk);
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(got == len, "R3 packet length", got, len);
        chk(done && !busy && !tx_valid, "R9 done after last byte", done, 1);
        chk(expect_reply == !wr, "R5 reply strobe", expect_reply, !wr);
        @(negedge clk);
        chk(!done && !expect_reply, "R9 done one cycle", done, 0);
    endtask

    task automatic run_reject(input int cnt);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_count = 6'(cnt); req_page = 8'h21;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject && !busy && !tx_valid, "R6 refusal pulse", req_reject, 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!tx_valid && !busy && !req_reject, "R6 nothing sent", tx_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !tx_valid && !done && !expect_reply && !req_reject, "R1 reset outputs", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !tx_valid, "R1 idle after reset", req_ready, 1);
        run_frame(1'b1, 8'h05, 8'h10, 1, 1, 0, 1'b0);   // R2 R3 R4 single register
        run_frame(1'b1, 8'hA3, 8'h00, 32, 2, 1, 1'b0);  // R3 full count, R8 stalls
        run_frame(1'b1, 8'h7F, 8'hFE, 0, 3, 0, 1'b0);   // R10 zero count
        run_frame(1'b0, 8'h12, 8'h34, 5, 4, 2, 1'b0);   // R5 read header only
        run_frame(1'b1, 8'h44, 8'h08, 9, 5, 1, 1'b1);   // R7 request while busy
        run_reject(33);                                  // R6 just above limit
        run_reject(63);                                  // R6 top of field
        run_frame(1'b0, 8'h00, 8'h00, 32, 6, 0, 1'b0);  // R5 read of 32
        run_frame(1'b1, 8'hFF, 8'h3C, 17, 7, 2, 1'b0);  // R4 R8 odd count
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule